// File: doc/BRIEF.md
# Spare Lane Substitution Crossbar

The block sits in front of six independent deserializer channels and feeds each one from its own primary serial lane, or from a single spare lane. A small select register names the one channel whose primary lane is swapped out for the spare. That displaced primary lane is not dropped: it goes out on a dedicated test output, so the suspect lane can still be watched while the spare carries the traffic. With no substitution selected, every channel takes its own lane and the test output is held at zero.

The data path is purely combinational. Only the select register is clocked. A write lands on a clock edge. In the cycle that follows a write that changes the routing, the block raises a one-cycle restart pulse on each channel whose source changed, so that channel can restart its lock search. Both the old and the new substituted channel get the pulse. Each lane carries a parameterised number of bits per cycle.

Top module: `spare_lane_xbar`

## Requirements
- R1: After reset no substitution is active: every channel output equals its own primary lane, the test output is zero and no restart bit is set.
- R2: After a write of code k (0 to 5), channel k outputs the spare lane and every other channel outputs its own primary lane.
- R3: While code k (0 to 5) is selected, the test output carries primary lane k.
- R4: Code 7 selects no substitution: all channels take their own lanes and the test output is zero.
- R5: Code 6 behaves exactly like code 7.
- R6: A write changes the routing only on the rising clock edge where the write enable is high. The data on the select input is ignored while the enable is low.
- R7: After a write that changes the effective selection, the restart output holds a one-cycle pulse in the next cycle. Its bits are set for the previously substituted channel and the newly substituted channel. "No substitution" contributes no bit. The pulse is low again one cycle later.
- R8: A write that leaves the effective selection unchanged, including 6 written while 7 is in effect, raises no restart bit.
- R9: Channel outputs and the test output follow changes on the lanes in the same cycle, without waiting for a clock edge. Each channel depends only on its own lane or the spare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_we_i | input | 1 | Select register write enable |
| sel_wdata_i | input | SEL_W (3) | Select code: 0..NUM_CH-1 picks the channel; otherwise no substitution |
| prim_i | input | NUM_CH*LANE_W | Primary lanes, channel k at bits [k*LANE_W +: LANE_W] |
| spare_i | input | LANE_W | Spare lane |
| ch_o | output | NUM_CH*LANE_W | Channel inputs, same packing as prim_i |
| tst_o | output | LANE_W | Displaced primary lane, zero when idle |
| resync_o | output | NUM_CH | One-cycle restart pulse per channel |

## Verification
The routing is exercised with each primary lane carrying a distinct word derived from a per-vector seed, and with a spare word chosen to differ from every primary word. This makes any wrong source choice visible on a specific channel. The select sequence moves between two live channels, from live to idle and back, repeats the same code, and writes 6 and 7 in turn. These cases separate a true selection change from a re-write that is only redundant or aliased, and they pin down which restart bits fire. Directed steps then toggle the lanes without a clock edge to show the combinational path, and present a select code with the enable low to show it is ignored.

// File: rtl/spare_xbar_pkg.sv
package spare_xbar_pkg;
  function automatic int unsigned sel_width(input int unsigned n_ch);
    return $clog2(n_ch + 1);
  endfunction
endpackage

// File: rtl/spare_sel_reg.sv
module spare_sel_reg #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  wdata_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [NUM_CH-1:0] oh_o,
  output logic [NUM_CH-1:0] resync_o
);
  localparam logic [SEL_W-1:0] NONE   = {SEL_W{1'b1}};
  localparam logic [SEL_W-1:0] N_CODE = SEL_W'(NUM_CH);

  logic [SEL_W-1:0]  sel_q, wr_norm;
  logic [NUM_CH-1:0] resync_q, oh_new;

  // codes at or above NUM_CH collapse onto NONE
  assign wr_norm = (wdata_i < N_CODE) ? wdata_i : NONE;

  always_comb begin
    for (int k = 0; k < NUM_CH; k++) begin
      oh_o[k]   = (sel_q == SEL_W'(k));
      oh_new[k] = (wr_norm == SEL_W'(k));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= NONE;
      resync_q <= '0;
    end else begin
      resync_q <= (we_i && wr_norm != sel_q) ? (oh_o | oh_new) : '0;
      if (we_i) sel_q <= wr_norm;
    end
  end

  assign sel_o    = sel_q;
  assign resync_o = resync_q;
endmodule

// File: rtl/spare_lane_mux.sv
module spare_lane_mux #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned LANE_W = 1
) (
  input  logic [NUM_CH*LANE_W-1:0] prim_i,
  input  logic [LANE_W-1:0]        spare_i,
  input  logic [NUM_CH-1:0]        oh_i,
  output logic [NUM_CH*LANE_W-1:0] ch_o
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign ch_o[k*LANE_W +: LANE_W] = oh_i[k] ? spare_i : prim_i[k*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/spare_tst_mux.sv
module spare_tst_mux #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned LANE_W = 1
) (
  input  logic [NUM_CH*LANE_W-1:0] prim_i,
  input  logic [NUM_CH-1:0]        oh_i,
  output logic [LANE_W-1:0]        tst_o
);
  // AND-OR select; zero when no bit of oh_i is set
  always_comb begin
    tst_o = '0;
    for (int k = 0; k < NUM_CH; k++)
      tst_o = tst_o | (prim_i[k*LANE_W +: LANE_W] & {LANE_W{oh_i[k]}});
  end
endmodule

// File: rtl/spare_lane_xbar.sv
module spare_lane_xbar #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned LANE_W = 1,
  localparam int unsigned SEL_W = spare_xbar_pkg::sel_width(NUM_CH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sel_we_i,
  input  logic [SEL_W-1:0]         sel_wdata_i,
  input  logic [NUM_CH*LANE_W-1:0] prim_i,
  input  logic [LANE_W-1:0]        spare_i,
  output logic [NUM_CH*LANE_W-1:0] ch_o,
  output logic [LANE_W-1:0]        tst_o,
  output logic [NUM_CH-1:0]        resync_o
);
  logic [SEL_W-1:0]  sel_w;
  logic [NUM_CH-1:0] oh_w;

  spare_sel_reg #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_sel (
    .clk_i, .rst_ni, .we_i(sel_we_i), .wdata_i(sel_wdata_i),
    .sel_o(sel_w), .oh_o(oh_w), .resync_o(resync_o)
  );

  spare_lane_mux #(.NUM_CH(NUM_CH), .LANE_W(LANE_W)) u_lane (
    .prim_i, .spare_i, .oh_i(oh_w), .ch_o
  );

  spare_tst_mux #(.NUM_CH(NUM_CH), .LANE_W(LANE_W)) u_tst (
    .prim_i, .oh_i(oh_w), .tst_o
  );
endmodule

// File: rtl/spare_lane_xbar_chk.sv
module spare_lane_xbar_chk #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned LANE_W = 1,
  parameter int unsigned SEL_W  = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     sel_we_i,
  input logic [SEL_W-1:0]         sel_i,
  input logic [NUM_CH*LANE_W-1:0] ch_i,
  input logic [NUM_CH*LANE_W-1:0] prim_i,
  input logic [LANE_W-1:0]        tst_i,
  input logic [NUM_CH-1:0]        resync_i
);
  localparam logic [SEL_W-1:0] NONE   = {SEL_W{1'b1}};
  localparam logic [SEL_W-1:0] N_CODE = SEL_W'(NUM_CH);

  AST_SEL_NORMALIZED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i < N_CODE) || (sel_i == NONE)); // R5
  AST_HOLD_WITHOUT_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_we_i |=> $stable(sel_i)); // R6
  AST_IDLE_TST_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == NONE) |-> (tst_i == '0)); // R4
  AST_IDLE_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == NONE) |-> (ch_i == prim_i)); // R4
  AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_we_i |=> (resync_i == '0)); // R7
  AST_PULSE_AT_MOST_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(resync_i) <= 2); // R7
  AST_NO_PULSE_SAME_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(sel_i) |-> (resync_i == '0)); // R8
endmodule

bind spare_lane_xbar spare_lane_xbar_chk #(.NUM_CH(NUM_CH), .LANE_W(LANE_W), .SEL_W(SEL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_we_i(sel_we_i), .sel_i(sel_w),
  .ch_i(ch_o), .prim_i(prim_i), .tst_i(tst_o), .resync_i(resync_o)
);

// File: tb/spare_lane_xbar_tb_top.sv
module spare_lane_xbar_tb_top;
  localparam int NC = 6;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [2:0]    wdata = '0;
  logic [NC*LW-1:0] prim = '0;
  logic [LW-1:0] spare = '0;
  logic [NC*LW-1:0] ch;
  logic [LW-1:0] tst;
  logic [NC-1:0] resync;

  int n_run = 0, n_fail = 0;
  int model_sel = 7;

  always #2.5 clk = ~clk;

  spare_lane_xbar #(.NUM_CH(NC), .LANE_W(LW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_we_i(we), .sel_wdata_i(wdata),
    .prim_i(prim), .spare_i(spare), .ch_o(ch), .tst_o(tst), .resync_o(resync)
  );

  // {code[2:0], seed[7:0], spare[7:0]}
  localparam int NV = 10;
  localparam logic [18:0] VEC [NV] = '{
    {3'd3, 8'h10, 8'hF0}, {3'd0, 8'h21, 8'hE1}, {3'd5, 8'h32, 8'hD2},
    {3'd5, 8'h43, 8'hC3}, {3'd7, 8'h54, 8'hB4}, {3'd6, 8'h65, 8'hA5},
    {3'd2, 8'h76, 8'h96}, {3'd6, 8'h87, 8'h07}, {3'd1, 8'h98, 8'h08},
    {3'd4, 8'hA9, 8'h09}
  };

  function automatic int norm(input int c);
    return (c < NC) ? c : 7;
  endfunction

  function automatic logic [NC-1:0] oh(input int s);
    logic [NC-1:0] r = '0;
    if (s < NC) r[s] = 1'b1;
    return r;
  endfunction

  task automatic set_lanes(input logic [7:0] seed, input logic [7:0] sp);
    for (int k = 0; k < NC; k++) prim[k*LW +: LW] = seed + 8'(k * 17);
    spare = sp;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_routing(input string req);
    logic [NC*LW-1:0] e_ch;
    logic [LW-1:0]    e_t;
    e_t = '0;
    for (int k = 0; k < NC; k++) begin
      e_ch[k*LW +: LW] = (k == model_sel) ? spare : prim[k*LW +: LW];
      if (k == model_sel) e_t = prim[k*LW +: LW];
    end
    chk({req, " ch"}, 64'(ch), 64'(e_ch));
    chk({req, " tst"}, 64'(tst), 64'(e_t));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++; n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    set_lanes(8'h05, 8'h5A);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_routing("R1");
    chk("R1 resync", 64'(resync), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_routing("R1 post-reset");

    for (int v = 0; v < NV; v++) begin
      int c, ns;
      logic [NC-1:0] e_r;
      c  = int'(VEC[v][18:16]);
      ns = norm(c);
      set_lanes(VEC[v][15:8], VEC[v][7:0]);
      we = 1'b1; wdata = 3'(c);
      #1;
      chk_routing("R6 before edge");
      e_r = (ns != model_sel) ? (oh(model_sel) | oh(ns)) : '0;
      @(negedge clk);
      model_sel = ns;
      // R2 R3 R4 R5 routing after the edge
      chk_routing(c < NC ? "R2/R3" : (c == 6 ? "R5" : "R4"));
      chk(e_r == 0 ? "R8 no pulse" : "R7 pulse", 64'(resync), 64'(e_r));
      we = 1'b0;
      @(negedge clk);
      chk("R7 pulse cleared", 64'(resync), 64'h0);
    end

    // R6: enable low, code ignored (model_sel is 4 here)
    wdata = 3'd0;
    @(negedge clk);
    @(negedge clk);
    chk_routing("R6 we low");
    chk("R6 resync", 64'(resync), 64'h0);

    // R9: lanes change between edges, outputs follow at once
    set_lanes(8'hC4, 8'h3C);
    #1;
    chk_routing("R9 comb sel4");
    prim[0 +: LW] = 8'hEE;
    #0.5;
    chk("R9 ch0 independent", 64'(ch[0 +: LW]), 64'hEE);
    chk("R9 ch1 unaffected", 64'(ch[LW +: LW]), 64'(8'hC4 + 8'd17));

    // R7: live to idle pulses only the old channel
    @(negedge clk);
    we = 1'b1; wdata = 3'd6;
    @(negedge clk);
    chk("R7 live->idle", 64'(resync), 64'(oh(4)));
    model_sel = 7;
    we = 1'b0;
    chk_routing("R5 idle after 6");
    @(negedge clk);
    chk("R7 cleared", 64'(resync), 64'h0);

    // R1: reset mid-run returns to idle
    we = 1'b1; wdata = 3'd2;
    @(negedge clk);
    we = 1'b0;
    rst_n = 1'b0;
    #1;
    model_sel = 7;
    chk_routing("R1 async reset");
    chk("R1 resync reset", 64'(resync), 64'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule